// File: doc/BRIEF.md
# Two-Space I2C Byte Target

This block is an I2C target that answers two separate 7-bit device addresses. One address opens a 48-byte register file. The other opens a 128-byte scratch memory. Each space keeps its own word pointer.

A master writes the device address with the direction bit cleared. The first data byte then sets the word pointer of that space. Any further bytes are stored one after another, and the pointer steps forward after each byte. To read, the master issues a start or repeated start with the direction bit set. The target then returns bytes from the current pointer, and keeps going for as long as the master acknowledges each byte.

The SCL and SDA inputs are sampled on the system clock through two-flop synchronisers. SDA is driven open-drain: the block only tells the pad when to pull the line low. A backup input makes the whole interface stay off the bus.

Top module: `i2cdual_target`

## Requirements
- R1: An address byte whose upper seven bits equal 6Fh is acknowledged and selects the register file. Bit 0 of the address byte is the direction: 0 means write and 1 means read.
- R2: An address byte whose upper seven bits equal 57h is acknowledged and selects a 128-byte memory. This memory is separate from the register file, so the same word index holds independent data in each space.
- R3: In a write, the first byte after the address loads the word pointer of the selected space. Every later byte is stored at the pointer, after which the pointer advances by one. Each of these bytes is acknowledged.
- R4: The register-file pointer wraps from 2Fh to 00h.
- R5: The memory pointer wraps from 7Fh to 00h. The memory uses only word bits [6:0].
- R6: In a read, the target sends the byte at the current pointer of the addressed space, MSB first, and the pointer then advances. A read may follow a repeated start or stand alone. After the master NACKs a byte, the target stops driving SDA.
- R7: While `backupMode` is high, the target acknowledges nothing, stores nothing and leaves SDA released.
- R8: An address byte that matches neither device address is not acknowledged. The bytes that follow it, up to the next start, are ignored.
- R9: In the register space, a word byte of 30h or above is not acknowledged. The pointer keeps its old value, and later bytes are ignored until the next start.
- R10: `sdaOe` high means pull SDA low. It is low after reset. It changes only while the synchronised SCL is low.
- R11: A stop returns the target to idle. A start or repeated start always restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| backupMode | input | 1 | High while on backup supply; the bus is ignored |
| sdaOe | output | 1 | High to pull SDA low |

## Verification
The bench writes every register and every memory byte in one page transfer per space. It then reads each space back in full and compares against values computed arithmetically. A design that wrote at the wrong pointer, or shared storage between the spaces, would return shifted or overwritten data.

Targeted transfers cross the 2Fh and 7Fh boundaries. A pointer that ran past the end would land on the wrong byte or on unwritten storage.

The bench also sends a foreign address, an out-of-range register word, and a full write while in backup. A design that acknowledged any of these would pull SDA low where the bench expects it high. A later current-address read then shows that no pointer or data changed.

The bench finally clocks SCL after a master NACK. A target that kept transmitting would show up as SDA held low.

// File: rtl/i2cdual_pkg.sv
package i2cdual_pkg;

  // Strobes from the bus controller into the datapath
  typedef struct packed {
    logic shiftIn;    // shift one received bit in
    logic setSpace;   // latch the selected address space
    logic spaceSel;   // 0 = register file, 1 = memory
    logic loadPtr;    // load word pointer from the received byte
    logic writeByte;  // store received byte at the pointer
    logic incPtr;     // advance pointer of the active space
    logic loadTx;     // load transmit byte from the pointer
    logic shiftTx;    // move to the next transmit bit
  } dpStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXACK, ST_ACK, ST_TX, ST_TXACK, ST_TXNEXT
  } busState_t;

  typedef enum logic [1:0] {
    PH_DEV, PH_WORD, PH_DATA
  } phase_t;

endpackage

// File: rtl/i2cdual_data.sv
module i2cdual_data
  import i2cdual_pkg::*;
#(
  parameter int REG_DEPTH = 48,
  parameter int MEM_DEPTH = 128
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sdaBit,
  input  dpStrobe_t stb,
  output logic [7:0] rxByte,
  output logic      txMsb,
  output logic      wordOk
);

  localparam int REG_PW = $clog2(REG_DEPTH);
  localparam int MEM_PW = $clog2(MEM_DEPTH);
  localparam logic [REG_PW-1:0] REG_LAST = REG_PW'(REG_DEPTH - 1);
  localparam logic [MEM_PW-1:0] MEM_LAST = MEM_PW'(MEM_DEPTH - 1);

  logic [7:0] rxShift;
  logic [7:0] txShift;
  logic       space;
  logic [REG_PW-1:0] ptrReg;
  logic [MEM_PW-1:0] ptrMem;
  logic [7:0] regFile [REG_DEPTH];
  logic [7:0] memFile [MEM_DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      space   <= 1'b0;
      ptrReg  <= '0;
      ptrMem  <= '0;
    end else begin
      if (stb.shiftIn) rxShift <= {rxShift[6:0], sdaBit};
      if (stb.setSpace) space <= stb.spaceSel;
      if (stb.loadPtr) begin
        if (space) ptrMem <= rxShift[MEM_PW-1:0];
        else       ptrReg <= rxShift[REG_PW-1:0];
      end else if (stb.incPtr) begin
        if (space) ptrMem <= (ptrMem == MEM_LAST) ? '0 : ptrMem + 1'b1;
        else       ptrReg <= (ptrReg == REG_LAST) ? '0 : ptrReg + 1'b1;
      end
      if (stb.loadTx) txShift <= space ? memFile[ptrMem] : regFile[ptrReg];
      else if (stb.shiftTx) txShift <= {txShift[6:0], 1'b0};
    end
  end

  // Storage has no reset; it is written only by the bus
  always_ff @(posedge clk) begin
    if (stb.writeByte) begin
      if (space) memFile[ptrMem] <= rxShift;
      else       regFile[ptrReg] <= rxShift;
    end
  end

  assign rxByte = rxShift;
  assign txMsb  = txShift[7];
  assign wordOk = space | (rxShift < 8'(REG_DEPTH));

  AST_REG_PTR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    32'(ptrReg) < REG_DEPTH); // R4
  AST_WRITE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeByte |-> !stb.loadTx && !stb.loadPtr && !stb.shiftIn); // R3

endmodule

// File: rtl/i2cdual_ctrl.sv
module i2cdual_ctrl
  import i2cdual_pkg::*;
#(
  parameter logic [6:0] REG_DEV = 7'h6F,
  parameter logic [6:0] MEM_DEV = 7'h57
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       backupMode,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  input  logic       wordOk,
  output dpStrobe_t  stb,
  output logic       sdaBit,
  output logic       sdaOe
);

  logic [1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev, sclS, sdaS;
  logic sclRise, sclFall, startEv, stopEv;

  busState_t state, nState;
  phase_t    phase, nPhase;
  logic [2:0] bitCnt, nCnt;
  logic readMode, nRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclS    = sclSync[1];
  assign sdaS    = sdaSync[1];
  assign sdaBit  = sdaS;
  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;
  assign startEv = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEv  = sclS & sclPrev & ~sdaPrev & sdaS;

  always_comb begin
    stb    = '0;
    nState = state;
    nPhase = phase;
    nCnt   = bitCnt;
    nRead  = readMode;
    if (backupMode) begin
      nState = ST_IDLE;
    end else if (startEv) begin
      nState = ST_RX;
      nPhase = PH_DEV;
      nCnt   = '0;
      nRead  = 1'b0;
    end else if (stopEv) begin
      nState = ST_IDLE;
    end else begin
      unique case (state)
        ST_RX: if (sclRise) begin
          stb.shiftIn = 1'b1;
          if (bitCnt == 3'd7) nState = ST_RXACK;
          else nCnt = bitCnt + 3'd1;
        end
        ST_RXACK: if (sclFall) begin
          nState = ST_ACK;
          unique case (phase)
            PH_DEV: begin
              if (rxByte[7:1] == REG_DEV || rxByte[7:1] == MEM_DEV) begin
                stb.setSpace = 1'b1;
                stb.spaceSel = (rxByte[7:1] == MEM_DEV);
                nRead  = rxByte[0];
                nPhase = PH_WORD;
              end else begin
                nState = ST_IDLE;
              end
            end
            PH_WORD: begin
              if (wordOk) begin
                stb.loadPtr = 1'b1;
                nPhase = PH_DATA;
              end else begin
                nState = ST_IDLE;
              end
            end
            default: begin
              stb.writeByte = 1'b1;
              stb.incPtr    = 1'b1;
            end
          endcase
        end
        ST_ACK: if (sclFall) begin
          nCnt = '0;
          if (readMode) begin
            stb.loadTx = 1'b1;
            nState = ST_TX;
          end else begin
            nState = ST_RX;
          end
        end
        ST_TX: if (sclFall) begin
          if (bitCnt == 3'd7) nState = ST_TXACK;
          else begin
            stb.shiftTx = 1'b1;
            nCnt = bitCnt + 3'd1;
          end
        end
        ST_TXACK: if (sclRise) begin
          stb.incPtr = 1'b1;
          nState = sdaS ? ST_IDLE : ST_TXNEXT;
        end
        ST_TXNEXT: if (sclFall) begin
          stb.loadTx = 1'b1;
          nCnt   = '0;
          nState = ST_TX;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= PH_DEV;
      bitCnt   <= '0;
      readMode <= 1'b0;
    end else begin
      state    <= nState;
      phase    <= nPhase;
      bitCnt   <= nCnt;
      readMode <= nRead;
    end
  end

  assign sdaOe = (state == ST_ACK) | ((state == ST_TX) & ~txMsb);

  AST_BACKUP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $past(backupMode) |-> !sdaOe && !stb.writeByte && !stb.loadPtr); // R7
  AST_NO_FOREIGN_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RXACK && phase == PH_DEV && sclFall &&
     rxByte[7:1] != REG_DEV && rxByte[7:1] != MEM_DEV) |=> !sdaOe); // R8
  AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && $past(sclS) && !$past(backupMode)) |-> $stable(sdaOe)); // R10
  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rstN)
    (stopEv && !backupMode) |=> state == ST_IDLE); // R11

endmodule

// File: rtl/i2cdual_target.sv
module i2cdual_target
  import i2cdual_pkg::*;
#(
  parameter logic [6:0] REG_DEV   = 7'h6F,
  parameter logic [6:0] MEM_DEV   = 7'h57,
  parameter int         REG_DEPTH = 48,
  parameter int         MEM_DEPTH = 128
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic backupMode,
  output logic sdaOe
);

  dpStrobe_t  stb;
  logic [7:0] rxByte;
  logic       txMsb, wordOk, sdaBit;

  i2cdual_ctrl #(.REG_DEV(REG_DEV), .MEM_DEV(MEM_DEV)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .backupMode(backupMode), .rxByte(rxByte), .txMsb(txMsb),
    .wordOk(wordOk), .stb(stb), .sdaBit(sdaBit), .sdaOe(sdaOe)
  );

  i2cdual_data #(.REG_DEPTH(REG_DEPTH), .MEM_DEPTH(MEM_DEPTH)) uData (
    .clk(clk), .rstN(rstN), .sdaBit(sdaBit), .stb(stb),
    .rxByte(rxByte), .txMsb(txMsb), .wordOk(wordOk)
  );

endmodule

// File: tb/sim_i2cdual_target.sv
module sim_i2cdual_target;

  localparam int Q = 6;
  localparam logic [7:0] REG_W = 8'hDE, REG_R = 8'hDF;
  localparam logic [7:0] MEM_W = 8'hAE, MEM_R = 8'hAF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, backupMode = 1'b0;
  logic sdaOe, sdaLine;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign sdaLine = sdaM & ~sdaOe;

  i2cdual_target u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .backupMode(backupMode), .sdaOe(sdaOe)
  );

  function automatic logic [7:0] regVal(int i);
    return 8'(i * 7 + 3);
  endfunction

  function automatic logic [7:0] memVal(int i);
    return 8'(i * 13) ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic putBit(input logic b);
    sdaM = b; waitQ();
    sclM = 1'b1; waitQ(); waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic getBit(output logic b);
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    b = sdaLine; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] v, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(b);
    ack = !b;
  endtask

  task automatic recvByte(output logic [7:0] v, input bit mAck);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      v[i] = b;
    end
    putBit(!mAck);
  endtask

  // Set a pointer, then read n bytes after a repeated start
  task automatic readAt(input logic [7:0] wr, input logic [7:0] rd,
                        input logic [7:0] word, input int n,
                        input string req, input logic [7:0] exp [4]);
    bit ack;
    logic [7:0] v;
    busStart();
    sendByte(wr, ack);
    sendByte(word, ack);
    busStart();
    sendByte(rd, ack);
    check(ack, req, ack, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(v, i != n - 1);
      check(v == exp[i], req, v, exp[i]);
    end
    busStop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic b;
    logic [7:0] v;
    logic [7:0] e [4];

    repeat (10) @(negedge clk);
    check(sdaOe == 1'b0, "R10 reset", sdaOe, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // Page write of the whole register file, then full read-back (R1 R3)
    busStart();
    sendByte(REG_W, ack); check(ack, "R1 reg write addr ack", ack, 1);
    sendByte(8'h00, ack); check(ack, "R3 word ack", ack, 1);
    for (int i = 0; i < 48; i++) begin
      sendByte(regVal(i), ack);
      check(ack, "R3 data ack", ack, 1);
    end
    busStop();
    busStart();
    sendByte(REG_W, ack);
    sendByte(8'h00, ack);
    busStart();
    sendByte(REG_R, ack); check(ack, "R1 reg read addr ack", ack, 1);
    for (int i = 0; i < 48; i++) begin
      recvByte(v, i != 47);
      check(v == regVal(i), "R6 reg sweep", v, regVal(i));
    end
    busStop();

    // Whole memory (R2)
    busStart();
    sendByte(MEM_W, ack); check(ack, "R2 mem write addr ack", ack, 1);
    sendByte(8'h00, ack);
    for (int i = 0; i < 128; i++) sendByte(memVal(i), ack);
    busStop();
    busStart();
    sendByte(MEM_W, ack);
    sendByte(8'h00, ack);
    busStart();
    sendByte(MEM_R, ack); check(ack, "R2 mem read addr ack", ack, 1);
    for (int i = 0; i < 128; i++) begin
      recvByte(v, i != 127);
      check(v == memVal(i), "R2 mem sweep", v, memVal(i));
    end
    busStop();

    // Register wrap 2Fh -> 00h (R4)
    busStart();
    sendByte(REG_W, ack); sendByte(8'h2E, ack);
    sendByte(8'h11, ack); sendByte(8'h22, ack); sendByte(8'h33, ack);
    check(ack, "R4 wrapped write ack", ack, 1);
    busStop();
    e = '{8'h11, 8'h22, 8'h33, 8'h00};
    readAt(REG_W, REG_R, 8'h2E, 3, "R4 reg wrap", e);

    // Memory wrap 7Fh -> 00h (R5)
    busStart();
    sendByte(MEM_W, ack); sendByte(8'h7F, ack);
    sendByte(8'h44, ack); sendByte(8'h55, ack);
    busStop();
    e = '{8'h44, 8'h55, 8'h00, 8'h00};
    readAt(MEM_W, MEM_R, 8'h7F, 2, "R5 mem wrap", e);

    // Index 0 differs between the spaces (R2)
    e = '{8'h55, 8'h00, 8'h00, 8'h00};
    readAt(MEM_W, MEM_R, 8'h00, 1, "R2 mem index0", e);
    e = '{8'h33, 8'h00, 8'h00, 8'h00};
    readAt(REG_W, REG_R, 8'h00, 1, "R2 reg index0", e);

    // Current-address read continues at 01h (R6)
    busStart();
    sendByte(REG_R, ack);
    recvByte(v, 1'b0);
    check(v == regVal(1), "R6 current address", v, regVal(1));
    // After master NACK the target must not drive (R6)
    getBit(b);
    check(b == 1'b1, "R6 released after nack", b, 1);
    busStop();

    // Foreign device address (R8)
    busStart();
    sendByte(8'hA0, ack); check(!ack, "R8 foreign addr nack", ack, 0);
    sendByte(8'h00, ack); check(!ack, "R8 following byte ignored", ack, 0);
    busStop();

    // Out-of-range register word (R9); pointer stays at 02h
    busStart();
    sendByte(REG_W, ack);
    sendByte(8'h30, ack); check(!ack, "R9 word 30h nack", ack, 0);
    sendByte(8'h99, ack); check(!ack, "R9 data ignored", ack, 0);
    busStop();
    busStart();
    sendByte(REG_R, ack);
    recvByte(v, 1'b0);
    check(v == regVal(2), "R9 pointer unchanged", v, regVal(2));
    busStop();

    // Backup mode (R7)
    backupMode = 1'b1;
    repeat (4) @(negedge clk);
    busStart();
    sendByte(REG_W, ack); check(!ack, "R7 backup nack", ack, 0);
    sendByte(8'h05, ack); check(!ack, "R7 backup word nack", ack, 0);
    sendByte(8'hEE, ack);
    busStop();
    check(sdaOe == 1'b0, "R7 backup released", sdaOe, 0);
    backupMode = 1'b0;
    repeat (4) @(negedge clk);
    e = '{regVal(5), 8'h00, 8'h00, 8'h00};
    readAt(REG_W, REG_R, 8'h05, 1, "R7 no write in backup", e);

    // Stop returns to idle (R11)
    repeat (20) @(negedge clk);
    check(sdaOe == 1'b0, "R11 idle after stop", sdaOe, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule